// File: doc/BRIEF.md
# I2C Register Target with Stuck-Bus Recovery

This block is an I2C target that presents a 128-byte register space behind a single pointer. A controller addresses it with the write bit, sends one command byte that loads the pointer, and may follow with data bytes that are stored one after another. To read, the controller issues a repeated start with the read bit, and the target returns registers from the pointer onward. The pointer steps by one per byte and wraps from the top entry back to entry zero.

The bus lines are sampled through a two-stage synchronizer on the system clock. Start and stop conditions are found from the synchronized lines. The target pulls SDA or SCL low through open-drain drive outputs. While an internal update is busy, it can hold SCL low after a falling edge, which stretches the clock.

A stuck-bus watchdog counts clock cycles in which the bus shows no activity. When the count expires, the target lets go of both lines. It then decides whether the bus recovered or whether another agent still holds it low. In the second case it parks in a low-power sleep state. It leaves that state once it sees both lines high, and afterwards it answers only to a fresh start condition.

Top module: `i2c_tgt`

## Requirements
- R1: While reset is asserted and in the cycle after it, both drive outputs are low (lines released) and `asleep` is low.
- R2: The target acknowledges only an address whose upper seven bits equal `TGT_ADDR` (default 0x55). Bit 0 of the address byte is 1 for a read. For any other address SDA stays released until the next start or stop, and no register changes.
- R3: In a write, the first byte after the address loads the pointer from its low seven bits. Each further byte is acknowledged, stored at the pointer, and advances the pointer by one.
- R4: After a repeated start with the read bit, the target sends the register at the pointer, most significant bit first. Each byte sent advances the pointer by one, including the last one, so the next read continues from there.
- R5: Pointer increments wrap from 0x7F to 0x00, for both reads and writes.
- R6: A NACK from the controller after a read byte ends the transfer. The target keeps SDA released until the next start or stop.
- R7: If `updBusy` is high when SCL falls during an addressed transfer, the target holds SCL low. It releases SCL in the cycle after `updBusy` goes low.
- R8: If `TIMEOUT` cycles pass with no SCL edge and without both lines high, the target releases SDA and SCL.
- R9: After that release, if a line is still low, `asleep` goes high and the target drives nothing. If both lines are high, the target returns to idle with `asleep` low.
- R10: `asleep` stays high until both lines are seen high. After waking, the target ignores bytes clocked without a preceding start condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| sclIn | input | 1 | Sampled SCL bus level |
| sdaIn | input | 1 | Sampled SDA bus level |
| updBusy | input | 1 | Internal update in progress; requests a clock stretch |
| sclDriveLow | output | 1 | Pull SCL low when high |
| sdaDriveLow | output | 1 | Pull SDA low when high |
| asleep | output | 1 | Target is in the low-power sleep state |

## Verification
The bench writes and then reads back three bytes straddling 0x7E–0x00. A pointer that saturated or ran to 0x80 would return the wrong third byte. It also reads once more without a command byte; a design that left the pointer in place after a NACKed byte would repeat the old value. A foreign address must draw no ACK and no write, and a clock pulse after a NACK must read high. Two timeout cases separate a target that was itself stretching, which must come back awake, from a bus held low by the controller, which must put the target to sleep. After waking, the target must refuse a byte sent without a start.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK, ST_WDATA,
    ST_WDATA_ACK, ST_RDATA, ST_RACK, ST_IGNORE, ST_RELEASE, ST_SLEEP
  } tgtState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic rxShift;
    logic bitClr;
    logic ptrLoad;
    logic memWrite;
    logic ptrInc;
    logic txLoad;
    logic txShift;
  } dpStrobe_t;

endpackage

// File: rtl/i2c_tgt_datapath.sv
module i2c_tgt_datapath
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int TIMEOUT = 100_000_000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  dpStrobe_t stb,
  output logic      sclNow,
  output logic      sdaNow,
  output logic      sclRise,
  output logic      sclFall,
  output logic      startSeen,
  output logic      stopSeen,
  output logic      stuckTimeout,
  output logic [7:0] rxByte,
  output logic [3:0] bitCnt,
  output logic      txBit
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(TIMEOUT + 1);

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic [CNT_W-1:0] idleCnt;
  logic [7:0] rxReg, txReg;
  logic [ADDR_W-1:0] ptr;
  logic [7:0] regs [DEPTH];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclNow    = sclSync[1];
  assign sdaNow    = sdaSync[1];
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  // bus activity watchdog: any SCL edge or an idle bus restarts it
  logic busQuiet;
  assign busQuiet = ~(sclRise | sclFall | (sclNow & sdaNow));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) idleCnt <= '0;
    else if (!busQuiet) idleCnt <= '0;
    else if (idleCnt != CNT_W'(TIMEOUT)) idleCnt <= idleCnt + 1'b1;
  end

  assign stuckTimeout = busQuiet && (idleCnt == CNT_W'(TIMEOUT - 1));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rxReg  <= '0;
      txReg  <= '0;
      ptr    <= '0;
      bitCnt <= '0;
    end else begin
      if (stb.rxShift) rxReg <= {rxReg[6:0], sdaNow};
      if (stb.bitClr) bitCnt <= '0;
      else if (stb.rxShift || stb.txShift) bitCnt <= bitCnt + 1'b1;
      if (stb.ptrLoad) ptr <= rxReg[ADDR_W-1:0];
      else if (stb.ptrInc) ptr <= ptr + 1'b1;
      if (stb.txLoad) txReg <= regs[ptr];
      else if (stb.txShift) txReg <= {txReg[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (stb.memWrite) regs[ptr] <= rxReg;
  end

  assign rxByte = rxReg;
  assign txBit  = txReg[7];
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h55
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclNow,
  input  logic       sdaNow,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic       stuckTimeout,
  input  logic [7:0] rxByte,
  input  logic [3:0] bitCnt,
  input  logic       txBit,
  input  logic       updBusy,
  output dpStrobe_t  stb,
  output logic       sdaDriveLow,
  output logic       sclDriveLow,
  output logic       asleep
);
  tgtState_e state, nxt;
  logic [2:0] relCnt;
  logic       stretch;
  logic       busHigh, byteFull, addressed;

  assign busHigh   = sclNow & sdaNow;
  assign byteFull  = (bitCnt == 4'd8);
  assign addressed = state inside {ST_ADDR_ACK, ST_CMD, ST_CMD_ACK, ST_WDATA,
                                   ST_WDATA_ACK, ST_RDATA, ST_RACK};

  always_comb begin
    nxt = state;
    stb = '0;
    case (state)
      ST_IDLE: ;
      ST_ADDR: begin
        stb.rxShift = sclRise;
        if (sclFall && byteFull) begin
          stb.bitClr = 1'b1;
          nxt = (rxByte[7:1] == TGT_ADDR) ? ST_ADDR_ACK : ST_IGNORE;
        end
      end
      ST_ADDR_ACK: if (sclFall) begin
        stb.bitClr = 1'b1;
        if (rxByte[0]) begin
          nxt = ST_RDATA;
          stb.txLoad = 1'b1;
        end else nxt = ST_CMD;
      end
      ST_CMD: begin
        stb.rxShift = sclRise;
        if (sclFall && byteFull) begin
          stb.ptrLoad = 1'b1;
          stb.bitClr  = 1'b1;
          nxt = ST_CMD_ACK;
        end
      end
      ST_CMD_ACK, ST_WDATA_ACK: if (sclFall) begin
        stb.bitClr = 1'b1;
        nxt = ST_WDATA;
      end
      ST_WDATA: begin
        stb.rxShift = sclRise;
        if (sclFall && byteFull) begin
          stb.memWrite = 1'b1;
          stb.ptrInc   = 1'b1;
          stb.bitClr   = 1'b1;
          nxt = ST_WDATA_ACK;
        end
      end
      ST_RDATA: if (sclFall) begin
        if (bitCnt == 4'd7) begin
          stb.ptrInc = 1'b1;
          stb.bitClr = 1'b1;
          nxt = ST_RACK;
        end else stb.txShift = 1'b1;
      end
      ST_RACK: begin
        if (sclRise && sdaNow) nxt = ST_IGNORE;
        else if (sclFall) begin
          stb.txLoad = 1'b1;
          stb.bitClr = 1'b1;
          nxt = ST_RDATA;
        end
      end
      ST_IGNORE: ;
      ST_RELEASE: if (relCnt == 3'd7) nxt = busHigh ? ST_IDLE : ST_SLEEP;
      ST_SLEEP: if (busHigh) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
    if (state != ST_RELEASE && state != ST_SLEEP) begin
      if (stuckTimeout) begin
        nxt = ST_RELEASE;
        stb = '0;
      end else if (startSeen) begin
        nxt = ST_ADDR;
        stb = '0;
        stb.bitClr = 1'b1;
      end else if (stopSeen) begin
        nxt = ST_IDLE;
        stb = '0;
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state   <= ST_IDLE;
      relCnt  <= '0;
      stretch <= 1'b0;
    end else begin
      state  <= nxt;
      relCnt <= (state == ST_RELEASE) ? relCnt + 1'b1 : 3'd0;
      if (!updBusy || nxt == ST_RELEASE || !addressed) stretch <= 1'b0;
      else if (sclFall) stretch <= 1'b1;
    end
  end

  assign sdaDriveLow = (state inside {ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK}) ||
                       (state == ST_RDATA && !txBit);
  assign sclDriveLow = stretch;
  assign asleep      = (state == ST_SLEEP);
endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h55,
  parameter int         ADDR_W   = 7,
  parameter int         TIMEOUT  = 100_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic updBusy,
  output logic sclDriveLow,
  output logic sdaDriveLow,
  output logic asleep
);
  dpStrobe_t  stb;
  logic       sclNow, sdaNow, sclRise, sclFall, startSeen, stopSeen, stuckTimeout, txBit;
  logic [7:0] rxByte;
  logic [3:0] bitCnt;

  i2c_tgt_datapath #(.ADDR_W(ADDR_W), .TIMEOUT(TIMEOUT)) uDp (
    .clk(clk), .rst(rst), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .sclNow(sclNow), .sdaNow(sdaNow), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .stuckTimeout(stuckTimeout),
    .rxByte(rxByte), .bitCnt(bitCnt), .txBit(txBit)
  );

  i2c_tgt_ctrl #(.TGT_ADDR(TGT_ADDR)) uCtrl (
    .clk(clk), .rst(rst), .sclNow(sclNow), .sdaNow(sdaNow), .sclRise(sclRise),
    .sclFall(sclFall), .startSeen(startSeen), .stopSeen(stopSeen),
    .stuckTimeout(stuckTimeout), .rxByte(rxByte), .bitCnt(bitCnt), .txBit(txBit),
    .updBusy(updBusy), .stb(stb), .sdaDriveLow(sdaDriveLow),
    .sclDriveLow(sclDriveLow), .asleep(asleep)
  );
endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker #(
  parameter int TIMEOUT = 16
) (
  input logic clk,
  input logic rst,
  input logic updBusy,
  input logic sclDriveLow,
  input logic sdaDriveLow,
  input logic asleep
);
  logic [31:0] holdCnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) holdCnt <= '0;
    else if (sclDriveLow) holdCnt <= holdCnt + 1'b1;
    else holdCnt <= '0;
  end

  assert_reset_release_R1: assert property (@(posedge clk)
    rst |=> (!sdaDriveLow && !sclDriveLow && !asleep));

  assert_stretch_needs_busy_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(sclDriveLow) |-> $past(updBusy));

  assert_stretch_drops_R7: assert property (@(posedge clk) disable iff (rst)
    !updBusy |=> !sclDriveLow);

  assert_hold_bounded_R8: assert property (@(posedge clk) disable iff (rst)
    holdCnt <= 32'(TIMEOUT + 8));

  assert_quiet_sleep_R9: assert property (@(posedge clk) disable iff (rst)
    asleep |-> (!sdaDriveLow && !sclDriveLow));
endmodule

bind i2c_tgt i2c_tgt_checker #(.TIMEOUT(TIMEOUT)) uChk (
  .clk(clk), .rst(rst), .updBusy(updBusy), .sclDriveLow(sclDriveLow),
  .sdaDriveLow(sdaDriveLow), .asleep(asleep)
);

// File: tb/tb_i2c_tgt.sv
module tb_i2c_tgt;
  localparam int TO = 300;
  localparam int Q  = 10;
  localparam logic [7:0] AW = 8'hAA;   // 0x55 with write bit
  localparam logic [7:0] AR = 8'hAB;   // 0x55 with read bit
  // {pointer, data}
  localparam logic [15:0] VEC [6] = '{16'h00_3C, 16'h7F_A5, 16'h10_5A,
                                      16'h40_FF, 16'h01_C3, 16'h7E_81};

  logic clk = 1'b0, rst = 1'b1, updBusy = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sclDriveLow, sdaDriveLow, asleep;
  logic busScl, busSda;
  int   nChk = 0, nBad = 0;
  logic done = 1'b0;
  logic sdaSeenLow;

  assign busScl = mScl & ~sclDriveLow;
  assign busSda = mSda & ~sdaDriveLow;

  always #10 clk = ~clk;   // 20 ns period

  i2c_tgt #(.TGT_ADDR(7'h55), .ADDR_W(7), .TIMEOUT(TO)) dut (
    .clk(clk), .rst(rst), .sclIn(busScl), .sdaIn(busSda), .updBusy(updBusy),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .asleep(asleep)
  );

  always @(negedge clk) if (sdaDriveLow) sdaSeenLow <= 1'b1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    mSda = 1'b1; waitQ(Q);
    mScl = 1'b1; waitQ(Q);
    mSda = 1'b0; waitQ(Q);
    mScl = 1'b0; waitQ(Q);
  endtask

  task automatic stopCond();
    mSda = 1'b0; waitQ(Q);
    mScl = 1'b1;
    while (!busScl) @(negedge clk);
    waitQ(Q);
    mSda = 1'b1; waitQ(Q);
  endtask

  task automatic putBit(input logic b);
    mSda = b; waitQ(Q);
    mScl = 1'b1;
    while (!busScl) @(negedge clk);
    waitQ(Q);
    mScl = 1'b0; waitQ(Q);
  endtask

  task automatic getBit(output logic b);
    mSda = 1'b1; waitQ(Q);
    mScl = 1'b1;
    while (!busScl) @(negedge clk);
    waitQ(Q / 2);
    b = busSda;
    waitQ(Q / 2);
    mScl = 1'b0; waitQ(Q);
  endtask

  task automatic putByte(input logic [7:0] d, output logic nack);
    for (int i = 7; i >= 0; i--) putBit(d[i]);
    getBit(nack);
  endtask

  task automatic getByte(input logic ackIt, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) getBit(d[i]);
    putBit(~ackIt);
  endtask

  task automatic writeReg(input logic [7:0] p, input logic [7:0] d);
    logic n;
    startCond();
    putByte(AW, n); chk("R2 own address ack", n, 0);
    putByte(p, n);  chk("R3 command ack", n, 0);
    putByte(d, n);  chk("R3 data ack", n, 0);
    stopCond();
  endtask

  task automatic readReg(input logic [7:0] p, output logic [7:0] d);
    logic n;
    startCond();
    putByte(AW, n);
    putByte(p, n);
    startCond();
    putByte(AR, n);
    getByte(1'b0, d);
    stopCond();
  endtask

  initial begin
    logic [7:0] rd;
    logic n, b;
    waitQ(5);
    chk("R1 reset sda", sdaDriveLow, 0);
    chk("R1 reset scl", sclDriveLow, 0);
    chk("R1 reset asleep", asleep, 0);
    rst = 1'b0;
    waitQ(5);

    // table walk: R3 / R4 write then read back
    for (int i = 0; i < 6; i++) begin
      writeReg(VEC[i][15:8], VEC[i][7:0]);
      readReg(VEC[i][15:8], rd);
      chk($sformatf("R4 readback vec %0d", i), rd, VEC[i][7:0]);
    end

    // R5 wrap on burst write and burst read
    startCond();
    putByte(AW, n); putByte(8'h7E, n);
    putByte(8'h11, n); chk("R3 burst ack 0", n, 0);
    putByte(8'h22, n); chk("R5 burst ack 1", n, 0);
    putByte(8'h33, n); chk("R5 burst ack 2", n, 0);
    stopCond();
    startCond();
    putByte(AW, n); putByte(8'h7E, n);
    startCond();
    putByte(AR, n); chk("R4 read address ack", n, 0);
    getByte(1'b1, rd); chk("R4 burst read 7E", rd, 8'h11);
    getByte(1'b1, rd); chk("R5 burst read 7F", rd, 8'h22);
    getByte(1'b0, rd); chk("R5 burst read wrapped 00", rd, 8'h33);
    // R6 after NACK the target stays off SDA
    waitQ(Q);
    chk("R6 sda released after nack", sdaDriveLow, 0);
    getBit(b); chk("R6 extra clock reads high", b, 1);
    stopCond();

    // R4 pointer advanced past the NACKed byte: read continues at 0x01
    startCond();
    putByte(AR, n);
    getByte(1'b0, rd); chk("R4 read continues at pointer", rd, 8'hC3);
    stopCond();

    // R2 foreign address: no ack, no write
    sdaSeenLow = 1'b0;
    startCond();
    putByte(8'h54, n); chk("R2 foreign address nack", n, 1);
    putByte(8'h10, n); chk("R2 foreign cmd nack", n, 1);
    putByte(8'hEE, n); chk("R2 foreign data nack", n, 1);
    stopCond();
    chk("R2 sda never driven", sdaSeenLow, 0);
    readReg(8'h10, rd); chk("R2 register untouched", rd, 8'h5A);

    // R7 clock stretch
    startCond();
    updBusy = 1'b1;
    putByte(AW, n);
    chk("R7 stretch while busy", sclDriveLow, 1);
    waitQ(20);
    chk("R7 still stretching", busScl, 0);
    updBusy = 1'b0;
    waitQ(2);
    chk("R7 release after busy", sclDriveLow, 0);
    putByte(8'h20, n); putByte(8'h77, n);
    stopCond();
    readReg(8'h20, rd); chk("R7 write through stretch", rd, 8'h77);

    // R8/R9 target itself holding SCL: release and stay awake
    startCond();
    updBusy = 1'b1;
    putByte(AW, n);
    mScl = 1'b1;
    waitQ(TO + 40);
    chk("R8 scl released on timeout", sclDriveLow, 0);
    chk("R8 bus free again", busScl, 1);
    chk("R9 awake when bus recovered", asleep, 0);
    updBusy = 1'b0;
    waitQ(10);

    // R9/R10 bus held low externally
    mScl = 1'b0; waitQ(5);
    mSda = 1'b0;
    waitQ(TO + 40);
    chk("R9 asleep while held low", asleep, 1);
    mScl = 1'b1;
    waitQ(40);
    chk("R10 stays asleep while sda low", asleep, 1);
    mSda = 1'b1;
    waitQ(20);
    chk("R10 wakes with both lines high", asleep, 0);
    mScl = 1'b0; waitQ(Q);
    putByte(AW, n); chk("R10 no ack without start", n, 1);
    stopCond();
    startCond();
    putByte(AW, n); chk("R10 ack after fresh start", n, 0);
    stopCond();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog all-R actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule